// File: doc/BRIEF.md
# Dual Mask-Filter Message Acceptance

This block decides whether an incoming bus message may be stored in a receive buffer. It joins the message identifier and its remote-request flag into one key. It then checks that key against a row of filter/mask pairs. A pair matches when every key bit that its mask selects equals the bit at the same position in its filter. Key bits whose mask bit is clear are ignored.

Software loads each filter through two byte-wide registers. The high register holds the upper filter bits. The low register holds the remaining bits in its upper part, and its lower bits always read back as zero. The filter registers have no reset, so their contents survive a reset. The masks come in as plain inputs.

When the frame-complete strobe is high at a clock edge, the block stores an accept flag and the index of the winning pair. The lowest-numbered matching pair wins. Both stored values hold until the next strobe.

Top module: `acc_dual_filter`

## Requirements
- R1: The comparison key is the 11-bit identifier in key bits 11:1 with the remote-request bit in key bit 0.
- R2: A pair matches when, for every bit position whose mask bit is 1, the key bit equals the filter bit.
- R3: A pair whose mask is all zeros matches any key.
- R4: When pair 0 matches, the stored index is 0, whatever pair 1 does.
- R5: When pair 0 does not match and pair 1 matches, the stored index is 1.
- R6: When no pair matches, the stored accept flag is 0 and the stored index is 0.
- R7: A write with `wr_hi`=1 loads filter bits 11:4 from `wr_data[7:0]`. A write with `wr_hi`=0 loads filter bits 3:0 from `wr_data[7:4]`, and `wr_data[3:0]` is discarded. A low-register readback returns the stored bits in `rd_data[7:4]` with `rd_data[3:0]` = 0.
- R8: The accept flag and index change only at a clock edge where `frame_done` is 1, and they hold their values at every other edge.
- R9: Reset clears the accept flag and the index to 0 and leaves the filter registers unchanged.
- R10: The remote-request bit takes part in the match: two keys that differ only in bit 0 give different results when the mask has bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Filter register write strobe |
| wr_pair | input | 1 | Pair selected for the write |
| wr_hi | input | 1 | 1 selects the high register, 0 selects the low register |
| wr_data | input | 8 | Write data |
| rd_pair | input | 1 | Pair selected for readback |
| rd_hi | input | 1 | 1 reads the high register, 0 reads the low register |
| rd_data | output | 8 | Readback data |
| mask_flat | input | 24 | Masks; pair p occupies bits p*12 +: 12 |
| msg_id | input | 11 | Identifier of the incoming message |
| msg_rtr | input | 1 | Remote-request bit of the incoming message |
| frame_done | input | 1 | Frame-complete strobe |
| acc_flag | output | 1 | Stored accept flag |
| acc_idx | output | 1 | Stored index of the winning pair |

## Verification
The bench builds the block with its default values: an 11-bit identifier, two pairs and byte-wide filter registers. The key is therefore 12 bits wide and the low register holds a 4-bit nibble. With two pairs, every priority case can be reached: only pair 0 matches, only pair 1 matches, both match, and neither matches. Narrowed masks and all-zero masks are exercised, as are keys that differ only in the remote-request bit. Discarded low-nibble write bits and filter contents kept across a reset are both checked at the readback port.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Register half selector used by the filter register bank
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

endpackage

// File: rtl/acc_filter_regs.sv
module acc_filter_regs
  import acc_pkg::*;
#(
  parameter int NPAIR = 2,
  parameter int KEY_W = 12,
  parameter int REG_W = 8,
  parameter int PW    = 1
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [PW-1:0]          wr_pair,
  input  logic                   wr_hi,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [PW-1:0]          rd_pair,
  input  logic                   rd_hi,
  output logic [REG_W-1:0]       rd_data,
  output logic [NPAIR*KEY_W-1:0] filt_flat
);

  localparam int LO_W  = KEY_W - REG_W;
  localparam int PAD_W = REG_W - LO_W;

  logic [REG_W-1:0] hi_q [NPAIR];
  logic [LO_W-1:0]  lo_q [NPAIR];

  half_e wr_half;
  half_e rd_half;
  assign wr_half = half_e'(wr_hi);
  assign rd_half = half_e'(rd_hi);

  // Place a low-register nibble in the upper part of the byte, zeros below
  function automatic logic [REG_W-1:0] pack_lo(input logic [LO_W-1:0] nib);
    return {nib, {PAD_W{1'b0}}};
  endfunction

  // Storage has no reset: contents are defined only by software writes
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic sel_w;
    assign sel_w = wr_en && (wr_pair == PW'(p));

    always_ff @(posedge clk) begin
      if (sel_w && wr_half == HALF_HI) begin
        hi_q[p] <= wr_data;
      end
      if (sel_w && wr_half == HALF_LO) begin
        lo_q[p] <= wr_data[REG_W-1 -: LO_W];
      end
    end

    assign filt_flat[p*KEY_W +: KEY_W] = {hi_q[p], lo_q[p]};
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (rd_pair == PW'(p)) begin
        rd_data = (rd_half == HALF_HI) ? hi_q[p] : pack_lo(lo_q[p]);
      end
    end
  end

endmodule

// File: rtl/acc_pair_cmp.sv
module acc_pair_cmp #(
  parameter int KEY_W = 12
) (
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] filt,
  input  logic [KEY_W-1:0] mask,
  output logic             hit
);

  // Mask bit 1 = compare, 0 = don't care
  function automatic logic masked_eq(input logic [KEY_W-1:0] k,
                                     input logic [KEY_W-1:0] f,
                                     input logic [KEY_W-1:0] m);
    return ((k ^ f) & m) == '0;
  endfunction

  assign hit = masked_eq(key, filt, mask);

endmodule

// File: rtl/acc_prio.sv
module acc_prio #(
  parameter int NPAIR = 2,
  parameter int IDX_W = 1
) (
  input  logic [NPAIR-1:0] hit_vec,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx
);

  // Lowest-numbered matching pair wins; no match yields index 0
  always_comb begin
    win_idx = '0;
    for (int p = NPAIR - 1; p >= 0; p--) begin
      if (hit_vec[p]) begin
        win_idx = IDX_W'(p);
      end
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/acc_dual_filter.sv
module acc_dual_filter #(
  parameter int ID_W  = 11,
  parameter int NPAIR = 2,
  parameter int REG_W = 8,
  localparam int KEY_W = ID_W + 1,
  localparam int PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int IDX_W = PW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PW-1:0]          wr_pair,
  input  logic                   wr_hi,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [PW-1:0]          rd_pair,
  input  logic                   rd_hi,
  output logic [REG_W-1:0]       rd_data,
  input  logic [NPAIR*KEY_W-1:0] mask_flat,
  input  logic [ID_W-1:0]        msg_id,
  input  logic                   msg_rtr,
  input  logic                   frame_done,
  output logic                   acc_flag,
  output logic [IDX_W-1:0]       acc_idx
);

  // Identifier in the upper key bits, remote-request flag in bit 0
  function automatic logic [KEY_W-1:0] form_key(input logic [ID_W-1:0] id,
                                                input logic rtr);
    return {id, rtr};
  endfunction

  logic [KEY_W-1:0]       key_w;
  logic [NPAIR*KEY_W-1:0] filt_flat;
  logic [NPAIR-1:0]       hit_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;

  assign key_w = form_key(msg_id, msg_rtr);

  acc_filter_regs #(
    .NPAIR(NPAIR), .KEY_W(KEY_W), .REG_W(REG_W), .PW(PW)
  ) i_regs (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_pair  (wr_pair),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .rd_pair  (rd_pair),
    .rd_hi    (rd_hi),
    .rd_data  (rd_data),
    .filt_flat(filt_flat)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_cmp
    acc_pair_cmp #(.KEY_W(KEY_W)) i_cmp (
      .key (key_w),
      .filt(filt_flat[p*KEY_W +: KEY_W]),
      .mask(mask_flat[p*KEY_W +: KEY_W]),
      .hit (hit_vec[p])
    );
  end

  acc_prio #(.NPAIR(NPAIR), .IDX_W(IDX_W)) i_prio (
    .hit_vec(hit_vec),
    .any_hit(any_hit),
    .win_idx(win_idx)
  );

  // Result captured on frame completion, held otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_flag <= 1'b0;
      acc_idx  <= '0;
    end else if (frame_done) begin
      acc_flag <= any_hit;
      acc_idx  <= any_hit ? win_idx : '0;
    end
  end

endmodule

// File: rtl/acc_dual_filter_chk.sv
module acc_dual_filter_chk #(
  parameter int NPAIR = 2,
  parameter int IDX_W = 1,
  parameter int PW    = 1,
  parameter int REG_W = 8,
  parameter int LO_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_done,
  input logic [NPAIR-1:0] hit_vec,
  input logic             acc_flag,
  input logic [IDX_W-1:0] acc_idx,
  input logic             wr_en,
  input logic [PW-1:0]    wr_pair,
  input logic             wr_hi,
  input logic [REG_W-1:0] wr_data,
  input logic [PW-1:0]    rd_pair,
  input logic             rd_hi,
  input logic [REG_W-1:0] rd_data
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(acc_flag) && $stable(acc_idx));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> acc_flag == $past(|hit_vec));

  p_pair0_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && hit_vec[0] |=> acc_idx == '0);

  p_pair1_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !hit_vec[0] && hit_vec[1] |=> acc_idx == IDX_W'(1));

  p_nomatch_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_flag |-> acc_idx == '0);

  p_lo_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_hi && !rd_hi && rd_pair == wr_pair && $stable(rd_pair)
    |=> rd_data == {$past(wr_data[REG_W-1 -: LO_W]), {(REG_W-LO_W){1'b0}}});

endmodule

bind acc_dual_filter acc_dual_filter_chk #(
  .NPAIR(NPAIR), .IDX_W(IDX_W), .PW(PW), .REG_W(REG_W), .LO_W(KEY_W - REG_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_done(frame_done),
  .hit_vec   (hit_vec),
  .acc_flag  (acc_flag),
  .acc_idx   (acc_idx),
  .wr_en     (wr_en),
  .wr_pair   (wr_pair),
  .wr_hi     (wr_hi),
  .wr_data   (wr_data),
  .rd_pair   (rd_pair),
  .rd_hi     (rd_hi),
  .rd_data   (rd_data)
);

// File: tb/test_acc_dual_filter.sv
module test_acc_dual_filter;

  localparam int CLK_PERIOD = 10;
  localparam int ID_W  = 11;
  localparam int NPAIR = 2;
  localparam int KEY_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [0:0]       wr_pair = '0;
  logic             wr_hi = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [0:0]       rd_pair = '0;
  logic             rd_hi = 1'b0;
  logic [7:0]       rd_data;
  logic [23:0]      mask_flat = '0;
  logic [ID_W-1:0]  msg_id = '0;
  logic             msg_rtr = 1'b0;
  logic             frame_done = 1'b0;
  logic             acc_flag;
  logic [0:0]       acc_idx;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic  acc;
    logic  idx;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  logic [KEY_W-1:0] mdl_filt [NPAIR];
  logic [KEY_W-1:0] mdl_mask [NPAIR];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_dual_filter i_acc_dual_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pair(wr_pair), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_pair(rd_pair), .rd_hi(rd_hi), .rd_data(rd_data),
    .mask_flat(mask_flat), .msg_id(msg_id), .msg_rtr(msg_rtr),
    .frame_done(frame_done), .acc_flag(acc_flag), .acc_idx(acc_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input int pair, input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_pair = pair[0:0]; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi) mdl_filt[pair][11:4] = d;
    else    mdl_filt[pair][3:0]  = d[7:4];
  endtask

  task automatic set_mask(input int pair, input logic [KEY_W-1:0] m);
    mdl_mask[pair] = m;
    mask_flat[pair*KEY_W +: KEY_W] = m;
  endtask

  task automatic read_chk(input int pair, input bit hi, input logic [7:0] expv, input string req);
    @(negedge clk);
    rd_pair = pair[0:0]; rd_hi = hi;
    #1;
    check(rd_data == expv, req, rd_data, expv);
  endtask

  // Bench model: bitwise equality or don't-care, lowest pair first
  task automatic send(input logic [ID_W-1:0] id, input logic rtr, input string tag);
    exp_t e;
    logic [KEY_W-1:0] k;
    k = {id, rtr};
    e.acc = 1'b0; e.idx = 1'b0; e.tag = tag;
    for (int p = NPAIR - 1; p >= 0; p--) begin
      if (&((k ~^ mdl_filt[p]) | ~mdl_mask[p])) begin
        e.acc = 1'b1; e.idx = p[0];
      end
    end
    @(negedge clk);
    msg_id = id; msg_rtr = rtr; frame_done = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  // Monitor: a result is due one edge after a strobe
  initial begin
    forever begin
      @(posedge clk);
      if (frame_done && rst_n) begin
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        check(acc_flag == e.acc, {e.tag, " accept"}, acc_flag, e.acc);
        check(acc_idx == e.idx, {e.tag, " index"}, acc_idx, e.idx);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic sav_acc;
    logic sav_idx;
    repeat (3) @(negedge clk);
    check(acc_flag == 1'b0, "R9 reset accept", acc_flag, 0);
    check(acc_idx == 1'b0, "R9 reset index", acc_idx, 0);
    rst_n = 1'b1;

    // Pair 0 filter: id 0x123, rtr 0 -> key 0x246; low-write junk nibble
    wr_reg(0, 1'b1, 8'h24);
    wr_reg(0, 1'b0, 8'h6A);
    // Pair 1 filter: id 0x456, rtr 1 -> key 0x8AD
    wr_reg(1, 1'b1, 8'h8A);
    wr_reg(1, 1'b0, 8'hD5);
    read_chk(0, 1'b1, 8'h24, "R7 high readback");
    read_chk(0, 1'b0, 8'h60, "R7 low readback zero pad");
    read_chk(1, 1'b0, 8'hD0, "R7 low readback pair1");

    set_mask(0, 12'hFFF);
    set_mask(1, 12'hFF0);

    send(11'h123, 1'b0, "R1 R2 R4 exact pair0");
    send(11'h123, 1'b1, "R10 rtr differs");
    send(11'h456, 1'b1, "R5 pair1 only");
    send(11'h450, 1'b0, "R2 R5 masked low bits");
    send(11'h45F, 1'b0, "R6 no match");
    send(11'h7FF, 1'b1, "R6 no match high");

    // Hold: change message without strobe
    send(11'h456, 1'b1, "R8 setup");
    @(negedge clk);
    sav_acc = acc_flag; sav_idx = acc_idx;
    msg_id = 11'h000; msg_rtr = 1'b0;
    repeat (4) @(negedge clk);
    check(acc_flag == sav_acc, "R8 hold accept", acc_flag, sav_acc);
    check(acc_idx == sav_idx, "R8 hold index", acc_idx, sav_idx);

    // All-zero mask on pair 1: accepts anything, pair 0 still first
    set_mask(1, 12'h000);
    send(11'h123, 1'b0, "R3 R4 both match");
    send(11'h7FF, 1'b0, "R3 pair1 catch-all");
    set_mask(0, 12'h000);
    send(11'h555, 1'b1, "R3 R4 both catch-all");

    // Reset clears result, keeps filters
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(acc_flag == 1'b0, "R9 reset clears accept", acc_flag, 0);
    rst_n = 1'b1;
    read_chk(1, 1'b1, 8'h8A, "R9 filter kept high");
    read_chk(0, 1'b0, 8'h60, "R9 filter kept low");

    // Mixed patterns with narrow masks
    set_mask(0, 12'hF0F);
    set_mask(1, 12'h0F1);
    for (int i = 0; i < 40; i++) begin
      send(ID_W'((i * 37 + 5) % 2048), i[0], "R2 mixed");
    end
    set_mask(0, 12'h001);
    set_mask(1, 12'h001);
    send(11'h3AA, 1'b0, "R10 rtr only mask");
    send(11'h3AA, 1'b1, "R10 rtr only mask set");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule